// File: doc/BRIEF.md
# Integer ALU with Status Flags Word

This block is an integer arithmetic and logic unit that keeps a 32-bit status flags word. A caller presents an operation code, an operand size (8, 16 or 32 bits), two operands and a valid strobe. On the clock edge that samples the strobe, the unit registers the result and updates the flags word. The six arithmetic flags follow fixed legacy rules: carry, parity, auxiliary carry, zero, sign and overflow.

The operations are add, add-with-carry, subtract, subtract-with-borrow, AND, OR, XOR and compare. There is also a load that replaces the flags word with an operand value. The load can change only the writable bit positions. The control bits are trap, interrupt enable, direction, I/O privilege, nested task, resume, virtual-8086, alignment check, virtual interrupt, virtual interrupt pending and identification. They are only stored. Nothing in the block acts on them.

Operation codes on `op_code`: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 compare, 8 flags load. Codes 9 to 15 do nothing. Size codes on `op_size`: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits.

Top module: `alu_flags_unit`

## Requirements
- R1: After reset `result` is 0 and `flags` is 32'h0000_0002.
- R2: Add (code 0) and add-with-carry (code 1) give the sum at the chosen size. Carry (bit 0) is set when the sum carries out of the top bit of that size. Add-with-carry adds the stored carry bit as the incoming carry.
- R3: Subtract (code 2) and subtract-with-borrow (code 3) give a minus b in two's complement. Carry (bit 0) is set when the subtraction borrows into the top bit. Subtract-with-borrow also subtracts the stored carry bit.
- R4: After any arithmetic or logic operation, parity (bit 2) is 1 exactly when the low 8 bits of the result contain an even number of ones, at every size.
- R5: After an arithmetic operation, auxiliary carry (bit 4) is 1 exactly when a carry or borrow crosses from bit 3 into bit 4.
- R6: Zero (bit 6) is 1 when the sized result is all zeros. Sign (bit 7) equals the top bit of the result at the chosen size.
- R7: After an arithmetic operation, overflow (bit 11) is 1 exactly when the signed result does not fit in the chosen size.
- R8: AND (4), OR (5) and XOR (6) produce the bitwise result and update parity, zero and sign. They clear carry and overflow and leave auxiliary carry unchanged.
- R9: Compare (code 7) sets the flags exactly as subtract would. `result` keeps its previous value.
- R10: Load (code 8) copies `op_a` into the writable positions only: bits 0, 2, 4, 6 to 14 and 16 to 21 (mask 32'h003F_7FD5). Bit 1 always reads 1. Bits 3, 5, 15 and 22 to 31 always read 0. `result` is unchanged.
- R11: A cycle with `op_valid` low, or with an unused code 9 to 15, changes neither `result` nor `flags`.
- R12: The result is zero above the chosen size. Operand bits above the size have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, sampled on the rising edge |
| op_code | input | 4 | Operation select |
| op_size | input | 2 | Operand size select |
| op_a | input | 32 | First operand, or the value for a flags load |
| op_b | input | 32 | Second operand |
| result | output | 32 | Registered result, zero-extended from the chosen size |
| flags | output | 32 | Status flags word |

## Verification
Directed cases pick operand pairs that separate the flags from one another:
- 0xFF + 0x01 at 8 bits sets carry, auxiliary carry and zero together.
- 0x7F + 0x01 sets overflow without carry.
- 0 - 1 at 16 bits gives an all-ones result with even low-byte parity, so parity and sign are seen apart from the wider result.
- A 32-bit compare of the most negative value against one sets signed overflow while `result` stays unchanged.

Chained add-with-carry and subtract-with-borrow check that the stored carry feeds the next operation.

A flags load of all ones, followed by a logic operation, shows that reserved bits stay fixed, that control bits survive, and that auxiliary carry is kept. Long streams of random operations, sizes, operands and idle cycles are then compared every cycle against a behavioural model. The model uses signed integer range checks in place of sign-bit rules.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
    localparam int NUM_LANES = 3;
    localparam int DATA_W    = 8 << (NUM_LANES - 1);
    localparam int FLAG_W    = 32;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
        OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_CMP = 4'd7,
        OP_LDF = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_32X = 2'd3
    } size_e;

    localparam int BIT_CF = 0;
    localparam int BIT_PF = 2;
    localparam int BIT_AF = 4;
    localparam int BIT_ZF = 6;
    localparam int BIT_SF = 7;
    localparam int BIT_OF = 11;

    localparam logic [FLAG_W-1:0] WR_MASK   = 32'h003F_7FD5;
    localparam logic [FLAG_W-1:0] FIXED_ONE = 32'h0000_0002;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } arith_flags_t;
endpackage

// File: rtl/alu_arith_core.sv
module alu_arith_core
    import alu_flags_pkg::*;
(
    input  logic [3:0]        op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cf_in,
    output logic [DATA_W-1:0] res,
    output arith_flags_t      fl
);
    logic is_sub, use_c, is_logic, cin_eff;
    logic [1:0] lane;
    logic [DATA_W-1:0] logic_raw;
    logic [DATA_W-1:0] lane_sum  [NUM_LANES];
    logic [DATA_W-1:0] lane_mask [NUM_LANES];
    logic [DATA_W-1:0] lane_top  [NUM_LANES];
    logic              lane_co   [NUM_LANES];
    logic a_s, b_s, r_s;

    always_comb begin
        is_sub    = 1'b0;
        use_c     = 1'b0;
        is_logic  = 1'b0;
        logic_raw = '0;
        case (op)
            OP_ADC:  use_c = 1'b1;
            OP_SUB:  is_sub = 1'b1;
            OP_SBB:  begin is_sub = 1'b1; use_c = 1'b1; end
            OP_CMP:  is_sub = 1'b1;
            OP_AND:  begin is_logic = 1'b1; logic_raw = a & b; end
            OP_OR:   begin is_logic = 1'b1; logic_raw = a | b; end
            OP_XOR:  begin is_logic = 1'b1; logic_raw = a ^ b; end
            default: ;
        endcase
        // a - b - borrow == a + ~b + !borrow
        cin_eff = is_sub ? ~(use_c & cf_in) : (use_c & cf_in);
    end

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        localparam int W = 8 << k;
        logic [W-1:0] bx;
        logic [W:0]   s;
        always_comb begin
            bx = is_sub ? ~b[W-1:0] : b[W-1:0];
            s  = {1'b0, a[W-1:0]} + {1'b0, bx} + {{W{1'b0}}, cin_eff};
        end
        assign lane_sum[k]  = DATA_W'(s[W-1:0]);
        assign lane_co[k]   = s[W];
        assign lane_mask[k] = DATA_W'({W{1'b1}});
        assign lane_top[k]  = DATA_W'(1) << (W - 1);
    end

    always_comb begin
        case (size)
            SZ_8:    lane = 2'd0;
            SZ_16:   lane = 2'd1;
            default: lane = 2'd2;
        endcase
        res = is_logic ? (logic_raw & lane_mask[lane]) : lane_sum[lane];
        a_s = |(a & lane_top[lane]);
        b_s = |(b & lane_top[lane]);
        r_s = |(res & lane_top[lane]);
        fl.pf = ~^res[7:0];
        fl.zf = (res == '0);
        fl.sf = r_s;
        fl.af = a[4] ^ b[4] ^ res[4];
        fl.cf = is_sub ? ~lane_co[lane] : lane_co[lane];
        fl.of = is_sub ? ((a_s != b_s) && (r_s != a_s))
                       : ((a_s == b_s) && (r_s != a_s));
    end
endmodule

// File: rtl/alu_flags_reg.sv
module alu_flags_reg
    import alu_flags_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_arith,
    input  logic              upd_logic,
    input  logic              load,
    input  logic [FLAG_W-1:0] load_val,
    input  arith_flags_t      fl,
    output logic [FLAG_W-1:0] flags
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= FIXED_ONE;
        end else if (load) begin
            flags <= (load_val & WR_MASK) | FIXED_ONE;
        end else if (upd_arith) begin
            flags[BIT_CF] <= fl.cf;
            flags[BIT_PF] <= fl.pf;
            flags[BIT_AF] <= fl.af;
            flags[BIT_ZF] <= fl.zf;
            flags[BIT_SF] <= fl.sf;
            flags[BIT_OF] <= fl.of;
        end else if (upd_logic) begin
            flags[BIT_CF] <= 1'b0;
            flags[BIT_PF] <= fl.pf;
            flags[BIT_ZF] <= fl.zf;
            flags[BIT_SF] <= fl.sf;
            flags[BIT_OF] <= 1'b0;
        end
    end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [1:0]        op_size,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags
);
    logic         wr_res, upd_arith, upd_logic, load;
    logic [DATA_W-1:0] core_res;
    arith_flags_t core_fl;

    always_comb begin
        wr_res    = 1'b0;
        upd_arith = 1'b0;
        upd_logic = 1'b0;
        load      = 1'b0;
        if (op_valid) begin
            unique case (op_code)
                OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                    wr_res    = 1'b1;
                    upd_arith = 1'b1;
                end
                OP_AND, OP_OR, OP_XOR: begin
                    wr_res    = 1'b1;
                    upd_logic = 1'b1;
                end
                OP_CMP:  upd_arith = 1'b1;
                OP_LDF:  load = 1'b1;
                default: ;
            endcase
        end
    end

    alu_arith_core u_core (
        .op    (op_code),
        .size  (op_size),
        .a     (op_a),
        .b     (op_b),
        .cf_in (flags[BIT_CF]),
        .res   (core_res),
        .fl    (core_fl)
    );

    alu_flags_reg u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_arith (upd_arith),
        .upd_logic (upd_logic),
        .load      (load),
        .load_val  (op_a),
        .fl        (core_fl),
        .flags     (flags)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (wr_res) begin
            result <= core_res;
        end
    end
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
    import alu_flags_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [1:0]        op_size,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] result,
    input logic [FLAG_W-1:0] flags
);
    logic is_lg, writes;
    assign is_lg  = op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR);
    assign writes = op_valid && (op_code <= OP_XOR);

    // R10
    reserved_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~WR_MASK) == FIXED_ONE);

    // R10
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_LDF) |=> flags == (($past(op_a) & WR_MASK) | FIXED_ONE));

    // R8
    logic_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_lg |=> (!flags[BIT_CF] && !flags[BIT_OF]));

    // R8
    logic_keeps_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_lg |=> flags[BIT_AF] == $past(flags[BIT_AF]));

    // R9
    compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CMP) |=> $stable(result));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(flags) && $stable(result)));

    // R6
    zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        writes |=> flags[BIT_ZF] == (result == '0));

    // R4
    parity_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        writes |=> flags[BIT_PF] == ~^result[7:0]);

    // R12
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (writes && op_size == SZ_8) |=> result[DATA_W-1:8] == '0);
endmodule

bind alu_flags_unit alu_flags_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_size  (op_size),
    .op_a     (op_a),
    .result   (result),
    .flags    (flags)
);

// File: tb/alu_flags_unit_tb.sv
`timescale 1ns/1ps
module alu_flags_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] result;
    logic [31:0] flags;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_res = '0;
    logic [31:0] m_flags = 32'h2;

    always #2.5 clk = ~clk;

    alu_flags_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_size(op_size), .op_a(op_a), .op_b(op_b), .result(result), .flags(flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference: integer ranges, counted ones
    task automatic model(input logic [3:0] op, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] b);
        int w;
        longint msk, am, bm, sa, sb, full, sr, c, r;
        bit cf, af, of, logic_op, wr;
        w   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        msk = (longint'(1) << w) - 1;
        am  = longint'(a) & msk;
        bm  = longint'(b) & msk;
        sa  = (am >= (longint'(1) << (w - 1))) ? am - (longint'(1) << w) : am;
        sb  = (bm >= (longint'(1) << (w - 1))) ? bm - (longint'(1) << w) : bm;
        c = 0; r = 0; cf = 0; af = 0; of = 0; logic_op = 0; wr = 1;
        if (op > 4'd8) return;
        if (op == 4'd8) begin
            m_flags = 32'h2;
            for (int i = 0; i < 22; i++)
                if (!(i inside {1, 3, 5, 15})) m_flags[i] = a[i];
            return;
        end
        case (op)
            4'd0, 4'd1: begin
                c    = (op == 4'd1) ? longint'(m_flags[0]) : 0;
                full = am + bm + c;
                r    = full & msk;
                cf   = ((full >> w) & 1) != 0;
                af   = ((am & 15) + (bm & 15) + c) > 15;
                sr   = sa + sb + c;
                of   = (sr >= (longint'(1) << (w - 1))) || (sr < -(longint'(1) << (w - 1)));
            end
            4'd2, 4'd3, 4'd7: begin
                c    = (op == 4'd3) ? longint'(m_flags[0]) : 0;
                full = am - bm - c;
                r    = full & msk;
                cf   = full < 0;
                af   = ((am & 15) - (bm & 15) - c) < 0;
                sr   = sa - sb - c;
                of   = (sr >= (longint'(1) << (w - 1))) || (sr < -(longint'(1) << (w - 1)));
                wr   = (op != 4'd7);
            end
            default: begin
                logic_op = 1;
                r = (op == 4'd4) ? (am & bm) : (op == 4'd5) ? (am | bm) : (am ^ bm);
            end
        endcase
        m_flags[0]  = cf;
        m_flags[11] = of;
        if (!logic_op) m_flags[4] = af;
        m_flags[2] = ($countones(r[7:0]) % 2) == 0;
        m_flags[6] = (r == 0);
        m_flags[7] = ((r >> (w - 1)) & 1) != 0;
        if (wr) m_res = r[31:0];
    endtask

    // called at a negedge: drive, let one rising edge pass, compare with model
    task automatic step(input string tag, input bit v, input logic [3:0] op,
                        input logic [1:0] sz, input logic [31:0] a, input logic [31:0] b);
        op_valid = v; op_code = op; op_size = sz; op_a = a; op_b = b;
        @(negedge clk);
        if (v) model(op, sz, a, b);
        chk({tag, " model result"}, result, m_res);
        chk({tag, " model flags"}, flags, m_flags);
    endtask

    function automatic string tag_of(input bit v, input logic [3:0] op);
        if (!v || op > 4'd8) return "R11";
        case (op)
            4'd0, 4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd7:       return "R9";
            4'd8:       return "R10";
            default:    return "R8";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset result", result, 32'h0);
        chk("R1 reset flags", flags, 32'h2);
        rst_n = 1'b1;

        step("R2 R5 R6 add carry", 1, 4'd0, 2'd0, 32'hFF, 32'h01);
        chk("R2 add8 result", result, 32'h00);
        chk("R2 R5 R6 add8 flags", flags, 32'h57);

        step("R2 adc", 1, 4'd1, 2'd0, 32'h10, 32'h20);
        chk("R2 adc uses carry", result, 32'h31);
        chk("R2 adc flags", flags, 32'h02);

        step("R7 add overflow", 1, 4'd0, 2'd0, 32'h7F, 32'h01);
        chk("R7 add8 result", result, 32'h80);
        chk("R7 R5 add8 flags", flags, 32'h892);

        step("R3 sub borrow", 1, 4'd2, 2'd1, 32'h0, 32'h1);
        chk("R3 sub16 result", result, 32'hFFFF);
        chk("R3 R4 sub16 flags", flags, 32'h97);

        step("R3 sbb", 1, 4'd3, 2'd1, 32'h5, 32'h3);
        chk("R3 sbb uses borrow", result, 32'h1);
        chk("R3 sbb flags", flags, 32'h2);

        step("R9 compare", 1, 4'd7, 2'd2, 32'h8000_0000, 32'h1);
        chk("R9 compare keeps result", result, 32'h1);
        chk("R9 R7 compare flags", flags, 32'h816);

        step("R10 load", 1, 4'd8, 2'd2, 32'hFFFF_FFFF, 32'h0);
        chk("R10 load flags", flags, 32'h003F_7FD7);
        chk("R10 load keeps result", result, 32'h1);

        step("R8 and", 1, 4'd4, 2'd0, 32'h0F, 32'hF0);
        chk("R8 and flags", flags, 32'h003F_7756);

        step("R11 idle", 0, 4'd0, 2'd0, 32'h1, 32'h1);
        chk("R11 idle flags", flags, 32'h003F_7756);
        step("R11 unused code", 1, 4'hF, 2'd0, 32'h1, 32'h1);
        chk("R11 unused code result", result, 32'h0);

        step("R10 clear", 1, 4'd8, 2'd0, 32'h0, 32'h0);
        step("R12 narrow add", 1, 4'd0, 2'd0, 32'h1234, 32'h0001);
        chk("R12 narrow result", result, 32'h35);
        chk("R12 R4 narrow flags", flags, 32'h6);

        step("R8 xor", 1, 4'd6, 2'd2, 32'h8000_0000, 32'h0);
        chk("R6 R8 xor32 flags", flags, 32'h86);
        step("R6 or16", 1, 4'd5, 2'd1, 32'h8000, 32'h0001);
        chk("R6 or16 sign flags", flags, 32'h82);

        for (int i = 0; i < 600; i++) begin
            logic [3:0] op;
            bit v;
            v  = ($urandom_range(0, 9) != 0);
            op = 4'($urandom_range(0, 11));
            step(tag_of(v, op), v, op, 2'($urandom_range(0, 3)), $urandom, $urandom);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule